// File: doc/BRIEF.md
# Serial Control Register File

This block is a processor-facing serial port for a bank of eight 5-bit control registers. A processor moves one 8-bit frame per strobe window over a shift clock and a data line. The frame carries a 3-bit register address and then 5 data bits. One strobe, active low, writes the addressed register. A second strobe, also active low, reads it back: the address is shifted in first, and the register contents are then shifted out on a data output with its own enable, all inside the same window.

The register contents drive parallel outputs. These are gain codes, a ringer volume code, path switch enables, a tone switch, tone and ringer control fields, power control and a general-purpose latch output. An active-low asynchronous reset returns every register to zero. All serial inputs are sampled on the system clock, and a rising edge of the shift clock is recognised when the sampled shift clock goes from low to high.

Top module: `ctl_serial_regs`

## Requirements
- R1: While `rst_ni` is low and right after it is released, every register reads zero, every field output is zero and `sdo_en_o` is low.
- R2: While `wr_ni` is low, `sdi_i` is sampled on each shift-clock rising edge, most significant bit first. The first three bits are the address and the next five are the data. When `wr_ni` returns high after exactly 8 rising edges, the data is stored in the addressed register.
- R3: While `rd_ni` is low and `wr_ni` is high, the first three rising edges shift in the address, most significant bit first. After the 3rd edge, `sdo_o` carries data bit 4 of the addressed register. Each later edge moves to the next lower bit. `sdo_en_o` is high from the 3rd edge until the 8th edge.
- R4: `sdo_en_o` is low at all times other than the data phase of a read, including during every write.
- R5: Register contents change only when a write commits. Reads and idle periods leave them unchanged.
- R6: A write frame with fewer or more than 8 rising edges is discarded, and no register changes.
- R7: In register 0, bits 4:3 drive `vol_a_o` and bits 2:0 drive `vol_b_o`. Code zero is the nominal 0 dB gain.
- R8: In register 1, bits 4:2 drive `vol_c_o` and bits 1:0 drive `ring_vol_o`. Code zero is the nominal gain and middle volume.
- R9: Register 2 bits 4:0 drive `path_en_o[4:0]`, one independent switch enable per bit.
- R10: In register 3, bit 1 drives `tone_sw_o` and bit 0 drives `latch_o`. Bits 4:2 are not stored and always read back as zero.
- R11: The registers at addresses 4, 5, 6 and 7 drive `pb_tone_o`, `svc_tone_o`, `ringer_o` and `power_o`, all five bits each.
- R12: Pulling `rst_ni` low in the middle of a frame clears all registers at once and abandons the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial inputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_en_o | output | 1 | Output enable for sdo_o; when low the pad is high impedance |
| vol_a_o | output | 2 | Register 0 gain code A |
| vol_b_o | output | 3 | Register 0 gain code B |
| vol_c_o | output | 3 | Register 1 gain code C |
| ring_vol_o | output | 2 | Register 1 ringer volume |
| path_en_o | output | 5 | Register 2 path switch enables |
| tone_sw_o | output | 1 | Register 3 tone switch enable |
| latch_o | output | 1 | Register 3 general-purpose latch |
| pb_tone_o | output | 5 | Register 4 push-button tone control |
| svc_tone_o | output | 5 | Register 5 service tone control |
| ringer_o | output | 5 | Register 6 ringer control |
| power_o | output | 5 | Register 7 power control |

## Verification
The bench builds the block with its default parameters: eight registers of five bits, so each frame is eight bits long. At this size the whole address space can be written and read back. The same setup covers the masked register 3 against the full-width registers, and the saturating frame counter on both sides of the commit count (7-bit and 9-bit frames). It also reaches a reset that arrives partway through a frame.

// File: rtl/ctl_serial_regs_pkg.sv
package ctl_serial_regs_pkg;
  localparam int unsigned NREGS = 8;
  localparam int unsigned DW    = 5;
  localparam int unsigned AW    = $clog2(NREGS);
  localparam int unsigned FW    = AW + DW;
  localparam int unsigned CW    = $clog2(FW + 2);
  localparam int unsigned IW    = $clog2(DW);

  localparam int unsigned REG_SW_LATCH = 3;
  localparam int unsigned LATCH_USED   = 2;

  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;
  typedef logic [CW-1:0] cnt_t;

  // storage mask: register 3 keeps only its low bits
  function automatic word_t reg_mask(input int unsigned idx);
    word_t m;
    m = '1;
    if (idx == REG_SW_LATCH) m = word_t'((1 << LATCH_USED) - 1);
    return m;
  endfunction
endpackage

// File: rtl/ctl_serial_regs_shift.sv
module ctl_serial_regs_shift
  import ctl_serial_regs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_i,
  input  logic  wr_ni,
  input  logic  rd_ni,
  input  logic  sdi_i,
  output cnt_t  cnt_o,
  output addr_t wr_addr_o,
  output word_t wr_data_o,
  output addr_t rd_addr_o,
  output logic  commit_o
);
  localparam cnt_t CNT_MAX = cnt_t'(FW + 1);
  localparam cnt_t CNT_FR  = cnt_t'(FW);
  localparam cnt_t CNT_AD  = cnt_t'(AW);

  logic          sclk_q, wr_q;
  cnt_t          cnt_q;
  logic [FW-1:0] shift_q;
  logic          rise, active, sh_en;

  assign rise   = sclk_i & ~sclk_q;
  assign active = ~wr_ni | ~rd_ni;
  // during a read only the address bits enter the shifter
  assign sh_en  = rise & active & (~wr_ni | (cnt_q < CNT_AD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      wr_q    <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      wr_q   <= wr_ni;
      if (!active)                        cnt_q <= '0;
      else if (rise && cnt_q != CNT_MAX)  cnt_q <= cnt_q + cnt_t'(1);
      if (sh_en) shift_q <= {shift_q[FW-2:0], sdi_i};
    end
  end

  assign commit_o  = wr_ni & ~wr_q & (cnt_q == CNT_FR);
  assign cnt_o     = cnt_q;
  assign wr_addr_o = shift_q[FW-1:DW];
  assign wr_data_o = shift_q[DW-1:0];
  assign rd_addr_o = shift_q[AW-1:0];
endmodule

// File: rtl/ctl_serial_regs_bank.sv
module ctl_serial_regs_bank
  import ctl_serial_regs_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  addr_t                    addr_i,
  input  word_t                    data_i,
  output logic [NREGS-1:0][DW-1:0] regs_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    localparam word_t MASK = reg_mask(g);
    word_t val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              val_q <= '0;
      else if (we_i && addr_i == addr_t'(g))    val_q <= data_i & MASK;
    end
    assign regs_o[g] = val_q;
  end
endmodule

// File: rtl/ctl_serial_regs_rdout.sv
module ctl_serial_regs_rdout
  import ctl_serial_regs_pkg::*;
(
  input  logic                     wr_ni,
  input  logic                     rd_ni,
  input  cnt_t                     cnt_i,
  input  addr_t                    addr_i,
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  output logic                     sdo_o,
  output logic                     sdo_en_o
);
  localparam cnt_t CNT_AD = cnt_t'(AW);
  localparam cnt_t CNT_FR = cnt_t'(FW);
  localparam cnt_t TOP_B  = cnt_t'(DW - 1);

  logic          in_win;
  cnt_t          off;
  logic [IW-1:0] bidx;
  word_t         word;

  assign in_win   = (cnt_i >= CNT_AD) && (cnt_i < CNT_FR);
  assign off      = cnt_i - CNT_AD;
  assign bidx     = IW'(TOP_B - off);
  assign word     = regs_i[addr_i];
  assign sdo_en_o = ~rd_ni & wr_ni & in_win;
  assign sdo_o    = sdo_en_o ? word[bidx] : 1'b0;
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctl_serial_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       wr_ni,
  input  logic       rd_ni,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_en_o,
  output logic [1:0] vol_a_o,
  output logic [2:0] vol_b_o,
  output logic [2:0] vol_c_o,
  output logic [1:0] ring_vol_o,
  output logic [4:0] path_en_o,
  output logic       tone_sw_o,
  output logic       latch_o,
  output logic [4:0] pb_tone_o,
  output logic [4:0] svc_tone_o,
  output logic [4:0] ringer_o,
  output logic [4:0] power_o
);
  cnt_t                     cnt_w;
  addr_t                    wr_addr_w, rd_addr_w;
  word_t                    wr_data_w;
  logic                     commit_w;
  logic [NREGS-1:0][DW-1:0] regs_w;

  ctl_serial_regs_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .wr_ni(wr_ni),
    .rd_ni(rd_ni), .sdi_i(sdi_i), .cnt_o(cnt_w), .wr_addr_o(wr_addr_w),
    .wr_data_o(wr_data_w), .rd_addr_o(rd_addr_w), .commit_o(commit_w)
  );

  ctl_serial_regs_bank u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(commit_w), .addr_i(wr_addr_w),
    .data_i(wr_data_w), .regs_o(regs_w)
  );

  ctl_serial_regs_rdout u_rdout (
    .wr_ni(wr_ni), .rd_ni(rd_ni), .cnt_i(cnt_w), .addr_i(rd_addr_w),
    .regs_i(regs_w), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
  );

  assign vol_a_o    = regs_w[0][4:3];
  assign vol_b_o    = regs_w[0][2:0];
  assign vol_c_o    = regs_w[1][4:2];
  assign ring_vol_o = regs_w[1][1:0];
  assign path_en_o  = regs_w[2];
  assign tone_sw_o  = regs_w[3][1];
  assign latch_o    = regs_w[3][0];
  assign pb_tone_o  = regs_w[4];
  assign svc_tone_o = regs_w[5];
  assign ringer_o   = regs_w[6];
  assign power_o    = regs_w[7];
endmodule

// File: rtl/ctl_serial_regs_chk.sv
module ctl_serial_regs_chk
  import ctl_serial_regs_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_ni,
  input logic                     rd_ni,
  input logic                     sdo_o,
  input logic                     sdo_en_o,
  input cnt_t                     cnt,
  input logic                     commit,
  input addr_t                    rd_addr,
  input logic [NREGS-1:0][DW-1:0] regs
);
  localparam cnt_t CNT_AD = cnt_t'(AW);
  localparam cnt_t CNT_FR = cnt_t'(FW);
  localparam cnt_t TOP_B  = cnt_t'(DW - 1);

  word_t         mask_w;
  logic [IW-1:0] bidx;
  assign mask_w = reg_mask(int'(rd_addr));
  assign bidx   = IW'(TOP_B - (cnt - CNT_AD));

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> (!rd_ni && wr_ni)); // R4

  AST_OE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> (cnt >= CNT_AD && cnt < CNT_FR)); // R3

  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_en_o && !mask_w[bidx]) |-> !sdo_o); // R10

  AST_CHANGE_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(regs) |-> $past(commit)); // R5

  AST_BAD_FRAME_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && !$past(wr_ni) && cnt != CNT_FR) |=> $stable(regs)); // R6
endmodule

bind ctl_serial_regs ctl_serial_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_ni(wr_ni), .rd_ni(rd_ni),
  .sdo_o(sdo_o), .sdo_en_o(sdo_en_o), .cnt(cnt_w), .commit(commit_w),
  .rd_addr(rd_addr_w), .regs(regs_w)
);

// File: tb/ctl_serial_regs_bench.sv
`timescale 1ns/1ps
module ctl_serial_regs_bench;
  logic clk = 0, rst_ni = 0, sclk = 0, wr_n = 1, rd_n = 1, sdi = 0;
  logic sdo, sdo_en;
  logic [1:0] vol_a, ring_vol;
  logic [2:0] vol_b, vol_c;
  logic [4:0] path_en, pb_tone, svc_tone, ringer, power;
  logic tone_sw, latch;

  always #2 clk = ~clk;

  ctl_serial_regs u_ctl_serial_regs (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .wr_ni(wr_n), .rd_ni(rd_n),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_en_o(sdo_en), .vol_a_o(vol_a),
    .vol_b_o(vol_b), .vol_c_o(vol_c), .ring_vol_o(ring_vol),
    .path_en_o(path_en), .tone_sw_o(tone_sw), .latch_o(latch),
    .pb_tone_o(pb_tone), .svc_tone_o(svc_tone), .ringer_o(ringer),
    .power_o(power)
  );

  int checks = 0, fails = 0, rd_falls = 0;
  logic [4:0] model [8];
  logic exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sclk();
    wait_clks(2); sclk = 1; wait_clks(4); sclk = 0; wait_clks(2);
  endtask

  function automatic logic [4:0] mask_of(input int a);
    return (a == 3) ? 5'b00011 : 5'b11111;
  endfunction

  // driver: write frame of nbits rising edges
  task automatic do_write(input logic [2:0] a, input logic [4:0] d, input int nbits);
    logic [8:0] fr;
    fr = {a, d, 1'b0};
    @(negedge clk); wr_n = 0; wait_clks(2);
    for (int i = 0; i < nbits; i++) begin
      sdi = fr[8-i];
      pulse_sclk();
      chk(sdo_en == 1'b0, "R4 oe during write", sdo_en, 0);
    end
    wr_n = 1; wait_clks(4);
    if (nbits == 8) model[a] = d & mask_of(a);
  endtask

  // driver: read frame, pushes expected data bits for the monitor
  task automatic do_read(input logic [2:0] a);
    for (int i = 4; i >= 0; i--) exp_q.push_back(model[a][i]);
    rd_falls = 0;
    @(negedge clk); rd_n = 0; wait_clks(2);
    for (int i = 0; i < 8; i++) begin
      sdi = (i < 3) ? a[2-i] : 1'b0;
      pulse_sclk();
    end
    rd_n = 1; wait_clks(4);
    chk(exp_q.size() == 0, "R3 all read bits seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // monitor: at each falling shift edge of a read, check enable and data
  initial forever begin
    @(negedge sclk);
    if (!rd_n) begin
      logic e;
      rd_falls++;
      chk(sdo_en == (rd_falls >= 3 && rd_falls <= 7), "R3 R4 oe window", sdo_en, rd_falls);
      if (sdo_en && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        chk(sdo == e, "R3 R10 read bit", sdo, e);
      end
    end
  end

  task automatic check_fields(input string tag);
    chk({vol_a, vol_b} == model[0], {"R7 ", tag}, {vol_a, vol_b}, model[0]);
    chk({vol_c, ring_vol} == model[1], {"R8 ", tag}, {vol_c, ring_vol}, model[1]);
    chk(path_en == model[2], {"R9 ", tag}, path_en, model[2]);
    chk({tone_sw, latch} == model[3][1:0], {"R10 ", tag}, {tone_sw, latch}, model[3][1:0]);
    chk({pb_tone, svc_tone, ringer, power} == {model[4], model[5], model[6], model[7]},
        {"R11 ", tag}, {pb_tone, svc_tone, ringer, power}, {model[4], model[5], model[6], model[7]});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    wait_clks(3);
    check_fields("reset R1");
    chk(sdo_en == 0, "R1 oe in reset", sdo_en, 0);
    rst_ni = 1; wait_clks(3);
    check_fields("after reset R1");

    do_write(3'd0, 5'b10110, 8); check_fields("R2 write r0");
    do_write(3'd1, 5'b01101, 8); check_fields("R2 write r1");
    do_write(3'd2, 5'b10101, 8); check_fields("R2 write r2");
    do_write(3'd3, 5'b11111, 8); check_fields("R2 write r3");
    do_write(3'd4, 5'b10011, 8);
    do_write(3'd5, 5'b01110, 8);
    do_write(3'd6, 5'b11001, 8);
    do_write(3'd7, 5'b00101, 8); check_fields("R2 write r4-r7");

    for (int a = 0; a < 8; a++) do_read(3'(a));
    check_fields("R5 after reads");

    do_write(3'd2, 5'b01010, 7); check_fields("R6 short frame");
    do_write(3'd2, 5'b01010, 9); check_fields("R6 long frame");
    do_read(3'd2);

    do_write(3'd3, 5'b00010, 8); check_fields("R10 latch low");
    chk(latch == 0, "R10 latch driven 0", latch, 0);
    do_write(3'd3, 5'b00001, 8);
    chk(latch == 1 && tone_sw == 0, "R10 latch driven 1", {tone_sw, latch}, 2'b01);
    do_read(3'd3);

    // R12: reset in mid-frame
    @(negedge clk); wr_n = 0;
    for (int i = 0; i < 4; i++) begin sdi = i[0]; pulse_sclk(); end
    rst_ni = 0; wait_clks(1);
    for (int i = 0; i < 8; i++) model[i] = '0;
    check_fields("R12 mid-frame reset");
    wr_n = 1; wait_clks(2); rst_ni = 1; wait_clks(3);
    do_write(3'd6, 5'b10001, 8); check_fields("R12 frame after reset");
    do_read(3'd6);

    summary();
  end
endmodule